// File: doc/BRIEF.md
# Event Fragment Merger

The merger gathers the per-event fragments produced by eight input-handler channels and sends them out as one contiguous event on a 64-bit AXI4-Stream master port. Each channel raises a ready flag once it holds its fragment for the current event. It also indicates whether that fragment is a full 75-word payload or was suppressed upstream. When every channel is ready, the merger raises `evt_ready`. An external event builder then launches the merge with a one-cycle `bld_start`.

The outgoing event opens with one header word that carries a running event number and a presence mask. The present channels follow in ascending channel order. Each present channel streams its 75 words with no idle cycles between channels. Suppressed channels take up no words; the mask tells downstream logic which channels were dropped. The channel interface is read-in-place: a channel presents its current word, advances on `ch_rd`, and is released by a `ch_done` pulse. A channel is never released before its whole fragment has been taken. Backpressure from `m_tready` freezes the stream without losing or repeating words.

Top module: `evt_frag_merger`

## Requirements
- R1: A merge starts only when `bld_start` is high while the merger is idle and all `ch_ready` bits are high. `evt_ready` is high exactly in that idle, all-ready condition. In any other case `bld_start` has no effect: no output word appears and no channel is read.
- R2: The first word of every event is a header. Bits 15:0 hold the event number, bits 23:16 hold the presence mask, and all other bits are zero. Mask bit c is 1 when `ch_suppr[c]` was low at the start cycle.
- R3: After the header, each present channel contributes exactly 75 words, taken in its own word order. Channels appear in ascending index order with no gap cycles between them. `ch_rd[c]` is high exactly in the cycles in which a word of channel c is accepted on the output.
- R4: A suppressed channel contributes no output words and never sees `ch_rd`.
- R5: `m_tlast` is high only on the final word of the event. When every channel is suppressed, that final word is the header.
- R6: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and the same word remains offered. No word is skipped or repeated, and `m_tvalid` does not drop in the middle of an event.
- R7: The event number is 0 after reset. It advances by one, modulo 2^16, in the cycle after the event's final word is accepted, and holds otherwise.
- R8: `ch_done[c]` pulses once per event. For a present channel it pulses in the cycle that channel's 75th word is accepted. For a suppressed channel it pulses in the cycle the header is accepted.
- R9: During and directly after reset, `m_tvalid`, `ch_rd`, `ch_done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_ready | input | 8 | Channel holds its fragment for the current event |
| ch_suppr | input | 8 | Channel fragment is suppressed (valid with ch_ready) |
| ch_data | input | 512 | Current word of each channel, channel c at bits 64c+63:64c |
| ch_rd | output | 8 | Word of channel c accepted this cycle, advance |
| ch_done | output | 8 | Fragment of channel c fully consumed, release |
| evt_ready | output | 1 | Idle and all channels ready |
| bld_start | input | 1 | Event-builder launch pulse |
| busy | output | 1 | An event is being emitted |
| m_tdata | output | 64 | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | Final word of the event |

## Verification
The in-RTL assertions check several properties on every cycle. A stall holds the position and the valid flag. At most one channel is read per cycle, and never a suppressed one. A present channel is released only on its last word. The event number moves only after a final-word handshake. An idle merger ignores a start that arrives without all channels ready. Other properties only the bench scenarios can show: the exact word sequence and header contents, the ascending gap-free channel order, and the tlast placement. The bench checks these for all 256 presence masks and under pseudo-random backpressure, with each expected word computed from the event number, channel and word index.

// File: rtl/emrg_pkg.sv
package emrg_pkg;

  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } mrg_state_e;

  // Header: event number in the low 16 bits, presence mask above it.
  function automatic logic [63:0] hdr_word(input logic [CNT_W-1:0] cnt,
                                           input logic [31:0] mask);
    return {16'h0000, mask, cnt};
  endfunction

endpackage

// File: rtl/emrg_chan_pick.sv
module emrg_chan_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   cur,
  output logic [CH_W-1:0]   first_idx,
  output logic [CH_W-1:0]   next_idx,
  output logic              next_vld
);

  // Lowest set bit of the mask, and lowest set bit strictly above cur.
  always_comb begin
    first_idx = '0;
    next_idx  = '0;
    next_vld  = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        first_idx = CH_W'(i);
        if (CH_W'(i) > cur) begin
          next_idx = CH_W'(i);
          next_vld = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/emrg_word_mux.sv
module emrg_word_mux #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 64,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH*DATA_W-1:0] ch_data,
  input  logic [CH_W-1:0]          sel,
  output logic [DATA_W-1:0]        word
);

  logic [DATA_W-1:0] lane [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assign lane[g] = ch_data[g*DATA_W +: DATA_W];
  end

  assign word = lane[sel];

endmodule

// File: rtl/emrg_ctrl.sv
module emrg_ctrl
  import emrg_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int FRAG_WORDS = 75,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W = (FRAG_WORDS > 1) ? $clog2(FRAG_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_ready,
  input  logic [NUM_CH-1:0] ch_suppr,
  input  logic              bld_start,
  input  logic              m_tready,
  output logic              m_tvalid,
  output logic              m_tlast,
  output logic              is_hdr,
  output logic [CH_W-1:0]   sel_ch,
  output logic [NUM_CH-1:0] mask_o,
  output logic [CNT_W-1:0]  evcnt_o,
  output logic [NUM_CH-1:0] ch_rd,
  output logic [NUM_CH-1:0] ch_done,
  output logic              evt_ready,
  output logic              busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAG_WORDS - 1);

  mrg_state_e        state_q;
  logic [NUM_CH-1:0] mask_q;
  logic [CH_W-1:0]   cur_q;
  logic [IDX_W-1:0]  widx_q;
  logic [CNT_W-1:0]  evcnt_q;

  // Named internal events
  logic              accept;
  logic              start_ev;
  logic              last_word;
  logic              hdr_acc;
  logic              data_acc;
  logic              evt_end;
  logic [NUM_CH-1:0] cur_oh;
  logic [CH_W-1:0]   first_idx;
  logic [CH_W-1:0]   next_idx;
  logic              next_vld;

  emrg_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
    .mask      (mask_q),
    .cur       (cur_q),
    .first_idx (first_idx),
    .next_idx  (next_idx),
    .next_vld  (next_vld)
  );

  assign m_tvalid  = (state_q != ST_IDLE);
  assign busy      = m_tvalid;
  assign is_hdr    = (state_q == ST_HDR);
  assign accept    = m_tvalid & m_tready;
  assign evt_ready = (state_q == ST_IDLE) & (&ch_ready);
  assign start_ev  = evt_ready & bld_start;
  assign last_word = (widx_q == LAST_IDX);
  assign hdr_acc   = accept & is_hdr;
  assign data_acc  = accept & (state_q == ST_DATA);
  assign cur_oh    = NUM_CH'(1) << cur_q;

  assign m_tlast = is_hdr ? (mask_q == '0)
                          : ((state_q == ST_DATA) & last_word & ~next_vld);
  assign evt_end = accept & m_tlast;

  assign ch_rd   = data_acc ? cur_oh : '0;
  assign ch_done = hdr_acc ? ~mask_q
                 : ((data_acc & last_word) ? cur_oh : '0);

  assign sel_ch  = cur_q;
  assign mask_o  = mask_q;
  assign evcnt_o = evcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      cur_q   <= '0;
      widx_q  <= '0;
      evcnt_q <= '0;
    end else begin
      if (evt_end) evcnt_q <= evcnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_ev) begin
            mask_q  <= ~ch_suppr;
            state_q <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (hdr_acc) begin
            if (mask_q == '0) begin
              state_q <= ST_IDLE;
            end else begin
              cur_q   <= first_idx;
              widx_q  <= '0;
              state_q <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (data_acc) begin
            if (!last_word) begin
              widx_q <= widx_q + 1'b1;
            end else if (next_vld) begin
              cur_q  <= next_idx;
              widx_q <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Stall keeps position and valid
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(cur_q) && $stable(widx_q)
                                 && $stable(state_q)));

  assert_one_reader_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rd));

  assert_no_read_suppr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rd & ~mask_q) == '0);

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_end |=> (evcnt_q == $past(evcnt_q) + 1'b1));

  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_end |=> $stable(evcnt_q));

  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !(bld_start && (&ch_ready))) |=> !m_tvalid);

  assert_done_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_done & mask_q) != '0) |-> ((state_q == ST_DATA) && last_word && accept));

endmodule

// File: rtl/evt_frag_merger.sv
module evt_frag_merger
  import emrg_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int FRAG_WORDS = 75,
  parameter int DATA_W     = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_ready,
  input  logic [NUM_CH-1:0]        ch_suppr,
  input  logic [NUM_CH*DATA_W-1:0] ch_data,
  output logic [NUM_CH-1:0]        ch_rd,
  output logic [NUM_CH-1:0]        ch_done,
  output logic                     evt_ready,
  input  logic                     bld_start,
  output logic                     busy,
  output logic [DATA_W-1:0]        m_tdata,
  output logic                     m_tvalid,
  input  logic                     m_tready,
  output logic                     m_tlast
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              is_hdr;
  logic [CH_W-1:0]   sel_ch;
  logic [NUM_CH-1:0] mask;
  logic [CNT_W-1:0]  evcnt;
  logic [DATA_W-1:0] pay_word;
  logic [63:0]       hdr;

  emrg_ctrl #(.NUM_CH(NUM_CH), .FRAG_WORDS(FRAG_WORDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_ready  (ch_ready),
    .ch_suppr  (ch_suppr),
    .bld_start (bld_start),
    .m_tready  (m_tready),
    .m_tvalid  (m_tvalid),
    .m_tlast   (m_tlast),
    .is_hdr    (is_hdr),
    .sel_ch    (sel_ch),
    .mask_o    (mask),
    .evcnt_o   (evcnt),
    .ch_rd     (ch_rd),
    .ch_done   (ch_done),
    .evt_ready (evt_ready),
    .busy      (busy)
  );

  emrg_word_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_mux (
    .ch_data (ch_data),
    .sel     (sel_ch),
    .word    (pay_word)
  );

  assign hdr     = hdr_word(evcnt, 32'(mask));
  assign m_tdata = is_hdr ? DATA_W'(hdr) : pay_word;

  assert_hdr_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_hdr |-> (ch_rd == '0));

endmodule

// File: tb/evt_frag_merger_tb.sv
module evt_frag_merger_tb;

  localparam int N  = 8;
  localparam int FW = 75;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ch_ready = '0;
  logic [N-1:0]  ch_suppr = '0;
  logic [N*64-1:0] ch_data;
  logic [N-1:0]  ch_rd, ch_done;
  logic          evt_ready, bld_start = 1'b0, busy;
  logic [63:0]   m_tdata;
  logic          m_tvalid, m_tlast;
  logic          m_tready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] bev = '0;
  logic [15:0] lfsr = 16'hACE1;
  int rp [N];
  bit finished = 0;

  evt_frag_merger u_dut (
    .clk(clk), .rst_n(rst_n), .ch_ready(ch_ready), .ch_suppr(ch_suppr),
    .ch_data(ch_data), .ch_rd(ch_rd), .ch_done(ch_done),
    .evt_ready(evt_ready), .bld_start(bld_start), .busy(busy),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] wexp(logic [15:0] ev, int c, int i);
    return {16'hDA7A, ev, 8'(c), 8'h00, 16'(i)};
  endfunction

  // Channel model: word pointer advances on rd, rewinds on done
  initial for (int c = 0; c < N; c++) rp[c] = 0;
  always_comb begin
    for (int c = 0; c < N; c++) ch_data[c*64 +: 64] = wexp(bev, c, rp[c]);
  end
  always @(posedge clk) begin
    for (int c = 0; c < N; c++) begin
      if (ch_done[c]) rp[c] <= 0;
      else if (ch_rd[c]) rp[c] <= rp[c] + 1;
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Runs one event with presence mask pm; stall enables random backpressure
  task automatic run_event(logic [N-1:0] pm, bit stall);
    int np, total, k, guard, pc, ci, wi, seen;
    logic [63:0] ew;
    logic [N-1:0] erd, edone;
    bit elast;
    np = $countones(pm);
    total = 1 + np * FW;
    @(negedge clk);
    ch_ready = '1; ch_suppr = ~pm; bld_start = 1'b1; m_tready = 1'b0;
    @(negedge clk);
    bld_start = 1'b0;
    k = 0; guard = 0;
    while (k < total && guard < 20000) begin
      if (stall) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_tready = lfsr[0];
      end else m_tready = 1'b1;
      #1;
      if (!m_tvalid) begin
        chk(0, "R6 valid dropped mid-event", 64'(m_tvalid), 64'd1);
      end else if (m_tready) begin
        if (k == 0) begin
          ew = {40'h0, pm, bev};
          erd = '0; edone = ~pm; elast = (np == 0);
          chk(m_tdata == ew, "R2 header", m_tdata, ew);
        end else begin
          pc = (k - 1) / FW; wi = (k - 1) % FW;
          ci = 0; seen = 0;
          for (int c = 0; c < N; c++) begin
            if (pm[c]) begin
              if (seen == pc) ci = c;
              seen++;
            end
          end
          ew = wexp(bev, ci, wi);
          erd = N'(1) << ci;
          edone = (wi == FW - 1) ? erd : '0;
          elast = (k == total - 1);
          chk(m_tdata == ew, "R3/R4 payload word", m_tdata, ew);
        end
        chk(m_tlast == elast, "R5 tlast", 64'(m_tlast), 64'(elast));
        chk(ch_rd == erd, "R3 ch_rd", 64'(ch_rd), 64'(erd));
        chk(ch_done == edone, "R8 ch_done", 64'(ch_done), 64'(edone));
        k++;
      end else begin
        chk(ch_rd == '0 && ch_done == '0, "R6 no side effect in stall",
            64'({ch_rd, ch_done}), 64'd0);
      end
      guard++;
      @(negedge clk);
    end
    m_tready = 1'b0;
    #1;
    chk(!m_tvalid && !busy, "R5 idle after last word", 64'(m_tvalid), 64'd0);
    ch_ready = '0;
    bev = bev + 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!m_tvalid && ch_rd == '0 && ch_done == '0 && !busy, "R9 reset state",
        64'({m_tvalid, busy, ch_rd, ch_done}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!m_tvalid && !busy, "R9 after reset", 64'(m_tvalid), 64'd0);

    // R1: start with one channel not ready is ignored
    ch_ready = 8'h7F; ch_suppr = '0; bld_start = 1'b1; m_tready = 1'b1;
    #1;
    chk(!evt_ready, "R1 evt_ready low when not all ready", 64'(evt_ready), 64'd0);
    repeat (4) @(negedge clk);
    chk(!m_tvalid && ch_rd == '0, "R1 start ignored", 64'(m_tvalid), 64'd0);
    bld_start = 1'b0;
    ch_ready = '1;
    #1;
    chk(evt_ready, "R1 evt_ready high when all ready", 64'(evt_ready), 64'd1);
    @(negedge clk);
    chk(!m_tvalid, "R1 no start without bld_start", 64'(m_tvalid), 64'd0);
    ch_ready = '0;

    // R7: event numbers from 0 counted through the header of each event
    for (int m = 0; m < 256; m++) run_event(N'(m), 1'b0);
    run_event(8'hFF, 1'b1);
    run_event(8'h5A, 1'b1);
    run_event(8'h80, 1'b1);
    run_event(8'h00, 1'b1);
    run_event(8'h01, 1'b1);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

endmodule